// File: doc/BRIEF.md
# Buffered SPI Slave Controller

This block is the device side of an SPI link that moves 8-bit characters. An external master owns the serial clock and the active-low select. While the master holds select low, the block shifts its own characters out on MISO and collects characters from MOSI. Two small FIFOs of four characters each sit between the serial side and a simple parallel port. The local logic writes characters to be sent into one FIFO and reads received characters from the other.

The clock polarity, the clock phase and the bit order are set by static configuration inputs. The master and the block always sample on the same clock edge, and the block updates MISO just after that edge. The select, clock and data pins are brought into the system clock domain through two-flop synchronizers. The system clock must therefore run at least eight times faster than the serial clock.

The transmit character for the next transfer is staged in a holding register. Staging happens at two points: when a character completes, and when a frame opens with nothing staged. If the transmit FIFO is empty at that point, the block raises an underrun pulse and stages a fallback character instead. A character staged from the FIFO is kept across a deselect. If a frame is cut short, that character is sent again from its first bit in the next frame.

Top module: `spi_slave_buf`

## Requirements
- R1: With select high, `spi_miso_oe` and `spi_miso` are 0, and serial clock edges receive nothing: `st_rx_valid` stays unchanged.
- R2: A falling select restarts the bit position. A partial character left by an early deselect is not stored, and the staged transmit character is sent again from its first bit.
- R3: The transmit FIFO holds 4 characters. A write while it is full is ignored, so the fifth written character is never sent.
- R4: A character that completes while the receive FIFO holds 4 characters is discarded and sets `st_rx_ovf`. The flag stays set until `ovf_clr` is pulsed.
- R5: `st_rx_valid` is 1 exactly when the receive FIFO is not empty, and `rd_data` shows the oldest character. `rd_en` removes that character. With the FIFO empty, `rd_data` is 0x00 and `rd_en` changes nothing.
- R6: Each 8-bit transfer sends exactly one staged character. Characters leave the transmit FIFO in the order they were written.
- R7: If the transmit FIFO is empty when a character must be staged, `tx_underrun` pulses for one cycle and a fallback is sent. With `cfg_repeat_last`=1 the fallback is the last character taken from the FIFO (0xFF if none has been taken since reset). With `cfg_repeat_last`=0 it is 0xFF.
- R8: `cfg_lsb_first`=1 shifts bit 0 first in both directions. With 0, bit 7 goes first.
- R9: Data is sampled on the rising serial clock edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise. The first bit is on MISO before the first sampling edge in all four modes.
- R10: `st_tx_idle` is 1 exactly when the transmit FIFO is empty and no character from the FIFO is staged or in flight. The last FIFO character completing sets it again.
- R11: `st_tx_free` is 0 exactly when the transmit FIFO holds 4 characters. It returns to 1 when a character is staged for shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_repeat_last | input | 1 | Underrun fallback: 1 repeat last, 0 send 0xFF |
| spi_sclk | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low select from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO output enable |
| wr_en | input | 1 | Push `wr_data` into transmit FIFO |
| wr_data | input | 8 | Character to transmit |
| rd_en | input | 1 | Pop the receive FIFO |
| rd_data | output | 8 | Oldest received character, 0x00 when empty |
| ovf_clr | input | 1 | Clear receive overflow flag |
| st_rx_valid | output | 1 | Receive FIFO not empty |
| st_rx_ovf | output | 1 | Sticky receive overflow |
| st_tx_free | output | 1 | Transmit FIFO has room |
| st_tx_idle | output | 1 | No transmit work pending |
| tx_underrun | output | 1 | One-cycle pulse on fallback staging |

## Verification
The bench goes after transfers that run past the end of the transmit FIFO. If the fallback were chosen wrongly there, the master would read a stale or wrong character; if a character were staged one transfer late, the whole stream would shift by one. It fills both FIFOs beyond their depth. A design that overwrote a stored character, or accepted a fifth write, would return data out of order. It also cuts frames short after a few bits. A design that did not restart the bit position would then store a corrupt character or resume halfway through the staged one. Random passes across all four clock modes and both bit orders expose any mismatch in the sampling edge or in the shift direction.

// File: rtl/spis_pkg.sv
// Shared constants for the buffered SPI slave.
// Assumes: characters are 8 bits and the FIFOs are small.
package spis_pkg;
    localparam int SPIS_CHAR_W      = 8;
    localparam int SPIS_FIFO_DEPTH  = 4;
    localparam int SPIS_SYNC_STAGES = 2;
endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; RST_VAL is the idle level of each pin.
module spis_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage retimes the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= RST_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spis_fifo.sv
// Small synchronous FIFO with a show-ahead head output.
// Assumes: a push while full and a pop while empty are dropped silently.
module spis_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (!do_push && do_pop) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spis_serdes.sv
// Bit engine: shifts received bits in, shifts staged transmit bits out,
// and stages the next transmit character or an underrun fallback.
// Assumes: sample pulses come only while selected, one per serial bit.
module spis_serdes #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_start,
    input  logic         sample,
    input  logic         mosi_bit,
    input  logic         lsb_first,
    input  logic         repeat_last,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_head,
    output logic         tx_pop,
    output logic         underrun,
    output logic         rx_done,
    output logic [W-1:0] rx_char,
    output logic         miso_bit,
    output logic         staged
);
    localparam int           CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] BUSY  = '1;

    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     rx_sh, tx_sh, tx_hold, last_q, fetched;
    logic             staged_q, rx_done_q, last_bit, fetch;

    assign last_bit = sample && (bit_cnt == CNT_W'(W-1));
    assign fetch    = (sel_start && !staged_q) || last_bit;
    assign tx_pop   = fetch && tx_avail;
    assign underrun = fetch && !tx_avail;
    assign fetched  = tx_avail ? tx_head : (repeat_last ? last_q : BUSY);
    assign miso_bit = lsb_first ? tx_sh[0] : tx_sh[W-1];
    assign rx_done  = rx_done_q;
    assign rx_char  = rx_sh;
    assign staged   = staged_q;

    // Receive shifting and bit position, restarted by a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_done_q <= 1'b0;
        end else begin
            rx_done_q <= last_bit;
            if (sel_start) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
            end else if (sample) begin
                bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                rx_sh   <= lsb_first ? {mosi_bit, rx_sh[W-1:1]}
                                     : {rx_sh[W-2:0], mosi_bit};
            end
        end
    end

    // Transmit staging, replay on reselect, and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh    <= BUSY;
            tx_hold  <= BUSY;
            last_q   <= BUSY;
            staged_q <= 1'b0;
        end else if (fetch) begin
            tx_sh    <= fetched;
            tx_hold  <= fetched;
            staged_q <= tx_avail;
            if (tx_avail) last_q <= tx_head;
        end else if (sel_start) begin
            tx_sh <= tx_hold;
        end else if (sample) begin
            tx_sh <= lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_slave_buf.sv
// Buffered SPI slave: synchronizes the pins, finds the sampling edge for
// the configured mode, and joins the bit engine to two character FIFOs.
// Assumes: clk runs at least 8x the serial clock; cfg_* change only
// while select is high.
module spi_slave_buf
    import spis_pkg::*;
#(
    parameter int CHAR_W      = SPIS_CHAR_W,
    parameter int FIFO_DEPTH  = SPIS_FIFO_DEPTH,
    parameter int SYNC_STAGES = SPIS_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_repeat_last,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    input  logic              ovf_clr,
    output logic              st_rx_valid,
    output logic              st_rx_ovf,
    output logic              st_tx_free,
    output logic              st_tx_idle,
    output logic              tx_underrun
);
    logic              cs_s, sclk_s, mosi_s, cs_prev, sclk_prev;
    logic              sel, sel_start, sample, rise_samples;
    logic              tx_pop, rx_done, miso_bit, staged, ovf_q;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CHAR_W-1:0] tx_head, rx_head, rx_char;

    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_mosi}),
        .q     ({cs_s, sclk_s, mosi_s})
    );

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign sel          = !cs_s;
    assign sel_start    = cs_prev && !cs_s;
    assign rise_samples = (cfg_cpol == cfg_cpha);
    assign sample       = sel && (rise_samples ? (sclk_s && !sclk_prev)
                                               : (!sclk_s && sclk_prev));

    spis_serdes #(.W(CHAR_W)) u_serdes (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_start   (sel_start),
        .sample      (sample),
        .mosi_bit    (mosi_s),
        .lsb_first   (cfg_lsb_first),
        .repeat_last (cfg_repeat_last),
        .tx_avail    (!tx_empty),
        .tx_head     (tx_head),
        .tx_pop      (tx_pop),
        .underrun    (tx_underrun),
        .rx_done     (rx_done),
        .rx_char     (rx_char),
        .miso_bit    (miso_bit),
        .staged      (staged)
    );

    spis_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    spis_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_done),
        .push_data (rx_char),
        .pop       (rd_en),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // Sticky overflow: a dropped character sets it, ovf_clr clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_q <= 1'b0;
        else if (rx_done && rx_full) ovf_q <= 1'b1;
        else if (ovf_clr)          ovf_q <= 1'b0;
    end

    assign spi_miso_oe = sel;
    assign spi_miso    = sel && miso_bit;
    assign rd_data     = rx_empty ? '0 : rx_head;
    assign st_rx_valid = !rx_empty;
    assign st_rx_ovf   = ovf_q;
    assign st_tx_free  = !tx_full;
    assign st_tx_idle  = tx_empty && !staged;
endmodule

// File: rtl/spis_checker.sv
// Protocol checks on the ports of spi_slave_buf, attached by bind.
// Assumes: reset is held low for a few cycles at start.
module spis_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       ovf_clr,
    input logic       st_rx_valid,
    input logic       st_rx_ovf,
    input logic       st_tx_free,
    input logic       st_tx_idle,
    input logic       tx_underrun
);
    // R1: a select held high long enough to pass the synchronizer silences MISO.
    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
        |-> !spi_miso_oe && !spi_miso);

    // R4: overflow stays set until cleared.
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_rx_ovf && !ovf_clr |=> st_rx_ovf);

    // R5: empty receive FIFO reads as zero.
    a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rx_valid |-> rd_data == 8'h00);

    // R5: the receive FIFO only empties after a read.
    a_r5_valid_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_rx_valid) |-> $past(rd_en));

    // R11: a full transmit FIFO can never be idle.
    a_r11_full_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_tx_free |-> !st_tx_idle);

    // R7: fallback staging happens only inside a frame.
    a_r7_underrun_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> spi_miso_oe);
endmodule

bind spi_slave_buf spis_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .ovf_clr     (ovf_clr),
    .st_rx_valid (st_rx_valid),
    .st_rx_ovf   (st_rx_ovf),
    .st_tx_free  (st_tx_free),
    .st_tx_idle  (st_tx_idle),
    .tx_underrun (tx_underrun)
);

// File: tb/tb_spi_slave_buf.sv
module tb_spi_slave_buf;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_repeat_last = 0;
    logic       spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
    logic       spi_miso, spi_miso_oe;
    logic       wr_en = 0, rd_en = 0, ovf_clr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       st_rx_valid, st_rx_ovf, st_tx_free, st_tx_idle, tx_underrun;

    int n_tests = 0;
    int n_fail  = 0;
    int und_seen = 0;

    // Reference model state.
    logic [7:0] m_txq[$];
    logic [7:0] m_rxq[$];
    logic [7:0] m_cur  = 8'hFF;
    logic [7:0] m_last = 8'hFF;
    logic       m_staged = 0;
    logic       m_ovf = 0;
    int         m_und = 0;

    always #2 clk = ~clk;

    spi_slave_buf dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_repeat_last(cfg_repeat_last),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ovf_clr(ovf_clr), .st_rx_valid(st_rx_valid), .st_rx_ovf(st_rx_ovf),
        .st_tx_free(st_tx_free), .st_tx_idle(st_tx_idle), .tx_underrun(tx_underrun)
    );

    always @(negedge clk) if (rst_n && tx_underrun) und_seen++;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Model: stage the next transmit character or a fallback.
    task automatic m_fetch();
        if (m_txq.size() > 0) begin
            m_cur = m_txq.pop_front();
            m_staged = 1;
            m_last = m_cur;
        end else begin
            m_cur = cfg_repeat_last ? m_last : 8'hFF;
            m_staged = 0;
            m_und++;
        end
    endtask

    function automatic logic exp_idle();
        return (m_txq.size() == 0) && !m_staged;
    endfunction

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (m_txq.size() < 4) m_txq.push_back(d);
    endtask

    task automatic cpu_read();
        logic [7:0] exp;
        @(negedge clk);
        exp = (m_rxq.size() > 0) ? m_rxq[0] : 8'h00;
        chk(rd_data == exp, "R5 read data", rd_data, exp);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        if (m_rxq.size() > 0) void'(m_rxq.pop_front());
    endtask

    task automatic check_status(input string where);
        @(negedge clk);
        chk(st_rx_valid == (m_rxq.size() > 0), {"R5 rx_valid ", where}, st_rx_valid, m_rxq.size() > 0);
        chk(st_rx_ovf == m_ovf, {"R4 ovf ", where}, st_rx_ovf, m_ovf);
        chk(st_tx_free == (m_txq.size() < 4), {"R11 tx_free ", where}, st_tx_free, m_txq.size() < 4);
        chk(st_tx_idle == exp_idle(), {"R10 tx_idle ", where}, st_tx_idle, exp_idle());
        chk(und_seen == m_und, {"R7 underrun count ", where}, und_seen, m_und);
    endtask

    // Master side: shift nbits of one character, capture MISO.
    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 0; b < nbits; b++) begin
            int idx;
            idx = cfg_lsb_first ? b : 7 - b;
            if (!cfg_cpha) begin
                spi_mosi = tx[idx];
                repeat (HALF) @(negedge clk);
                rx[idx] = spi_miso;
                spi_sclk = ~cfg_cpol;
                repeat (HALF) @(negedge clk);
                spi_sclk = cfg_cpol;
            end else begin
                repeat (HALF) @(negedge clk);
                spi_sclk = ~cfg_cpol;
                spi_mosi = tx[idx];
                repeat (HALF) @(negedge clk);
                rx[idx] = spi_miso;
                spi_sclk = cfg_cpol;
            end
        end
    endtask

    // One frame of nbytes full characters plus an optional cut-off tail.
    task automatic run_frame(input int nbytes, input int tail_bits);
        logic [7:0] tx, got, exp;
        @(negedge clk);
        spi_cs_n = 0;
        repeat (2 * HALF) @(negedge clk);
        if (!m_staged) m_fetch();
        for (int k = 0; k < nbytes; k++) begin
            tx = 8'($urandom);
            exp = m_cur;
            spi_bits(tx, 8, got);
            chk(got == exp, "R6/R8/R9 MISO char", got, exp);
            if (m_rxq.size() < 4) m_rxq.push_back(tx);
            else m_ovf = 1;
            m_fetch();
        end
        if (tail_bits > 0) spi_bits(8'h5A, tail_bits, got);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic lsb, input logic rep);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_repeat_last = rep;
        spi_sclk = pol;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // Reset state.
        chk(spi_miso_oe == 0, "R1 reset oe", spi_miso_oe, 0);
        chk(rd_data == 8'h00, "R5 reset rd_data", rd_data, 0);
        check_status("reset");

        // R5: read of empty FIFO returns 0 and changes nothing.
        cpu_read();
        check_status("empty read");

        // R7: repeat mode before any FIFO character sends 0xFF.
        set_mode(0, 0, 0, 1);
        run_frame(1, 0);
        check_status("R7 repeat at reset");

        // R6/R7: two characters then 0xFF fallback, mode 0 MSB first.
        set_mode(0, 0, 0, 0);
        cpu_write(8'hA5);
        cpu_write(8'h3C);
        check_status("R10 after writes");
        run_frame(3, 0);
        check_status("R7 busy fallback");
        for (int i = 0; i < 3; i++) cpu_read();

        // R7: repeat of last sent character.
        set_mode(1, 1, 1, 1);
        cpu_write(8'h5B);
        run_frame(3, 0);
        check_status("R7 repeat last");
        for (int i = 0; i < 3; i++) cpu_read();

        // R3/R4/R11: overfill both FIFOs.
        set_mode(0, 1, 0, 0);
        for (int i = 0; i < 5; i++) cpu_write(8'(8'h10 + i));
        check_status("R3 R11 full");
        run_frame(5, 0);
        check_status("R4 overflow");
        for (int i = 0; i < 5; i++) cpu_read();
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; m_ovf = 0;
        check_status("R4 clear");

        // R2: cut a frame short, the staged character replays in full.
        set_mode(1, 0, 1, 0);
        cpu_write(8'hC3);
        cpu_write(8'h96);
        run_frame(0, 3);
        check_status("R2 after abort");
        run_frame(2, 0);
        check_status("R2 replay");
        for (int i = 0; i < 2; i++) cpu_read();

        // R1: clocking with select high receives nothing, MISO silent.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            spi_sclk = ~spi_sclk; spi_mosi = 1'($urandom);
            repeat (HALF - 1) @(negedge clk);
            if (spi_miso_oe || spi_miso) chk(0, "R1 miso while deselected", {spi_miso_oe, spi_miso}, 0);
        end
        spi_sclk = cfg_cpol;
        repeat (8) @(negedge clk);
        chk(spi_miso_oe == 0, "R1 oe deselected", spi_miso_oe, 0);
        check_status("R1 deselected clocks");

        // Random mix across modes, bit orders and fallbacks.
        void'($urandom(32'd1234));
        for (int it = 0; it < 50; it++) begin
            set_mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            for (int w = 0, nw = $urandom_range(0, 5); w < nw; w++) cpu_write(8'($urandom));
            check_status("random writes");
            run_frame($urandom_range(1, 5), ($urandom_range(0, 5) == 0) ? $urandom_range(1, 7) : 0);
            check_status("random frame");
            for (int r = 0, nr = $urandom_range(0, 5); r < nr; r++) cpu_read();
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; m_ovf = 0;
            end
            check_status("random reads");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule